// File: doc/BRIEF.md
# Aligned Programmable Clock Divider Bank

This block derives three system clocks from one fast source clock. Every output has its own divider with a 5-bit ratio field and an enable bit. A set of small registers controls the block through plain write and read strobes. The registers cover the dividers, a mask that selects which outputs take part in realignment, a command register and a busy flag.

A ratio written to a divider is only staged. The running divide rate stays the same until software issues a GO command. During GO, each selected output is parked low at the end of its current period. Once every selected output is parked, the selected outputs are held low for one more source cycle. They are then released together, so their first rising edges coincide and each runs at its staged ratio. Outputs outside the mask keep toggling through the whole sequence at their previous rate.

All outputs are levels that are updated once per source cycle. A divider with ratio field r has a period of r+1 source cycles. Its output is high for the first part of each period.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, reading address k (k = 0, 1, 2) returns 16'h8000 | k, which means enable bit 15 set and ratio k. The align mask (address 3) reads 0, the busy status (address 5) reads 0 and the enable status (address 6) reads 3'b111.
- R2: With ratio field r in bits 4:0, an enabled output has a period of r+1 source cycles. It is high for the first max(1, floor((r+1)/2)) cycles of each period, so ratio 0 holds the output high.
- R3: Writing a divider register changes its read-back value at once. The output keeps its previous ratio until a GO operation commits the new value.
- R4: Writing 1 to bit 0 of the command register (address 4) starts a GO operation. Bit 0 of the status register (address 5) reads 1 from the next cycle until the operation ends. The command register always reads 0.
- R5: A command write made while the busy flag is 1 is ignored. No second GO operation follows the first.
- R6: In the first cycle in which the busy flag reads 0 again, every enabled output selected by the align mask (address 3, bit k for output k) is high. From that cycle on, each of these outputs follows the R2 pattern of its newly committed ratio, counted from that cycle.
- R7: An output whose align bit is 0 keeps running through a GO operation at its old ratio, even when a new ratio is staged for it. Its staged value remains readable.
- R8: A selected output is re-phased by GO even when its ratio is unchanged.
- R9: Clearing bit 15 of a divider register forces that output low. It also clears the matching bit of the enable status register (address 6).
- R10: Only bits 2:0 of the align mask are writable. The other bits of that register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| sysClk | output | 3 | Divided system clocks, bit k is output k |

## Verification
The main function is the commit of staged ratios. It is exercised with directed sets that separate its cases. One set leaves the ratio staged but uncommitted, which shows whether writes leak into the output. One set keeps a ratio unchanged while the output is still selected, which shows whether re-phasing happens. One set uses a partial mask, which shows whether unselected outputs are left undisturbed. A second command is sent while a GO is in flight, which shows whether it is dropped. Random ratio triplets across the full 0 to 31 range, all selected, then check the shared first rising edge and the exact high/low pattern for 64 cycles. This covers even and odd ratios and the divide-by-one case. Enable toggling confirms the forced-low output and the status bit.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CLK_N   = 3;
  localparam int RATIO_W = 5;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int EN_BIT  = 15;

  localparam logic [ADDR_W-1:0] ADDR_ALIGN = ADDR_W'(CLK_N);
  localparam logic [ADDR_W-1:0] ADDR_CMD   = ADDR_W'(CLK_N + 1);
  localparam logic [ADDR_W-1:0] ADDR_BUSY  = ADDR_W'(CLK_N + 2);
  localparam logic [ADDR_W-1:0] ADDR_RUN   = ADDR_W'(CLK_N + 3);

  typedef enum logic [1:0] {
    GO_IDLE = 2'd0,
    GO_ARM  = 2'd1,
    GO_HOLD = 2'd2
  } goState_t;

  typedef struct packed {
    logic [CLK_N-1:0] parkStb;
    logic [CLK_N-1:0] relStb;
  } dpStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWe,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [DATA_W-1:0]                 regWdata,
  output logic [DATA_W-1:0]                 regRdata,
  input  logic [CLK_N-1:0]                  atEnd,
  input  logic [CLK_N-1:0]                  parked,
  output logic [CLK_N-1:0][RATIO_W-1:0]     ratioStg,
  output logic [CLK_N-1:0]                  clkEn,
  output logic [CLK_N-1:0]                  selMask,
  output logic                              busy,
  output dpStrobe_t                         strb
);
  logic [CLK_N-1:0] alnMask;
  goState_t         state;
  logic             goAccept;
  logic             allParked;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < CLK_N; k++) begin
        ratioStg[k] <= RATIO_W'(k);
      end
      clkEn   <= '1;
      alnMask <= '0;
    end else if (regWe) begin
      for (int k = 0; k < CLK_N; k++) begin
        if (regAddr == ADDR_W'(k)) begin
          ratioStg[k] <= regWdata[RATIO_W-1:0];
          clkEn[k]    <= regWdata[EN_BIT];
        end
      end
      if (regAddr == ADDR_ALIGN) begin
        alnMask <= regWdata[CLK_N-1:0];
      end
    end
  end

  assign goAccept  = regWe && (regAddr == ADDR_CMD) && regWdata[0] && (state == GO_IDLE);
  assign allParked = ((parked & selMask) == selMask);
  assign busy      = (state != GO_IDLE);

  // GO sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= GO_IDLE;
      selMask <= '0;
    end else begin
      unique case (state)
        GO_IDLE: if (goAccept) begin
          selMask <= alnMask;
          state   <= GO_ARM;
        end
        GO_ARM:  if (allParked) state <= GO_HOLD;
        GO_HOLD: state <= GO_IDLE;
        default: state <= GO_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.parkStb = '0;
    strb.relStb  = '0;
    if (state == GO_ARM)  strb.parkStb = selMask & atEnd & ~parked;
    if (state == GO_HOLD) strb.relStb  = selMask;
  end

  // read mux
  always_comb begin
    regRdata = '0;
    for (int k = 0; k < CLK_N; k++) begin
      if (regAddr == ADDR_W'(k)) begin
        regRdata[EN_BIT]        = clkEn[k];
        regRdata[RATIO_W-1:0]   = ratioStg[k];
      end
    end
    if (regAddr == ADDR_ALIGN) regRdata[CLK_N-1:0] = alnMask;
    if (regAddr == ADDR_BUSY)  regRdata[0]         = busy;
    if (regAddr == ADDR_RUN)   regRdata[CLK_N-1:0] = clkEn;
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CLK_N-1:0][RATIO_W-1:0] ratioStg,
  input  logic [CLK_N-1:0]              clkEn,
  input  dpStrobe_t                     strb,
  output logic [CLK_N-1:0]              atEnd,
  output logic [CLK_N-1:0]              parked,
  output logic [CLK_N-1:0]              sysClk
);
  localparam int HI_W = RATIO_W + 1;

  for (genvar g = 0; g < CLK_N; g++) begin : gChan
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] actRatio;
    logic               isParked;
    logic [HI_W-1:0]    hiLen;

    assign hiLen = (actRatio == '0) ? HI_W'(1)
                 : (({1'b0, actRatio} + HI_W'(1)) >> 1);

    assign atEnd[g]  = (cnt == actRatio);
    assign parked[g] = isParked;
    assign sysClk[g] = clkEn[g] && !isParked && ({1'b0, cnt} < hiLen);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt      <= '0;
        actRatio <= RATIO_W'(g);
        isParked <= 1'b0;
      end else if (strb.relStb[g]) begin
        actRatio <= ratioStg[g];
        cnt      <= '0;
        isParked <= 1'b0;
      end else if (strb.parkStb[g]) begin
        cnt      <= '0;
        isParked <= 1'b1;
      end else if (!isParked) begin
        cnt <= (cnt == actRatio) ? '0 : cnt + RATIO_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [CLK_N-1:0]  sysClk
);
  logic [CLK_N-1:0][RATIO_W-1:0] ratioStg;
  logic [CLK_N-1:0]              clkEn;
  logic [CLK_N-1:0]              selMask;
  logic [CLK_N-1:0]              atEnd;
  logic [CLK_N-1:0]              parked;
  logic                          busy;
  dpStrobe_t                     strb;

  clkdiv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .atEnd    (atEnd),
    .parked   (parked),
    .ratioStg (ratioStg),
    .clkEn    (clkEn),
    .selMask  (selMask),
    .busy     (busy),
    .strb     (strb)
  );

  clkdiv_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ratioStg (ratioStg),
    .clkEn    (clkEn),
    .strb     (strb),
    .atEnd    (atEnd),
    .parked   (parked),
    .sysClk   (sysClk)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic [CLK_N-1:0]  sysClk,
  input logic [CLK_N-1:0]  parked,
  input logic [CLK_N-1:0]  selMask,
  input logic [CLK_N-1:0]  relStb,
  input logic [CLK_N-1:0]  clkEn,
  input logic              busy
);
  logic cmdWrite;
  assign cmdWrite = regWe && (regAddr == ADDR_CMD) && regWdata[0];

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdWrite));

  // R4
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CMD) |-> (regRdata == '0));

  // R10
  align_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_ALIGN) |-> (regRdata[DATA_W-1:CLK_N] == '0));

  for (genvar g = 0; g < CLK_N; g++) begin : gChk
    // R6
    parked_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      parked[g] |-> !sysClk[g]);

    // R7
    unsel_free_chk: assert property (@(posedge clk) disable iff (!rstN)
      !selMask[g] |-> !parked[g]);

    // R6
    release_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      (relStb[g] && clkEn[g] && !(regWe && regAddr == ADDR_W'(g))) |=> sysClk[g]);

    // R9
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !clkEn[g] |-> !sysClk[g]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .sysClk   (sysClk),
  .parked   (parked),
  .selMask  (selMask),
  .relStb   (strb.relStb),
  .clkEn    (clkEn),
  .busy     (busy)
);

// File: tb/sim_clkdiv_bank.sv
module sim_clkdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [2:0]  sysClk;

  int nTests = 0;
  int nFails = 0;
  bit done = 0;
  int curR [NCH];

  clkdiv_bank u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sysClk(sysClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expHi(int r);
    return (r == 0) ? 1 : (r + 1) / 2;
  endfunction

  function automatic bit expLevel(int r, int t);
    return (t % (r + 1)) < expHi(r);
  endfunction

  function automatic int expCount(int r, int len);
    return (len / (r + 1)) * expHi(r);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic countHigh(int ch, int len, output int n);
    n = 0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      n += int'(sysClk[ch]);
    end
  endtask

  // issue GO, confirm busy, wait for completion; returns at first idle cycle
  task automatic runGo(string req);
    logic [15:0] d;
    int guard;
    wr(3'd4, 16'h0001);
    rd(3'd5, d);
    check("R4", int'(d[0]), 1, {req, " busy after command"});
    rd(3'd4, d);
    check("R4", int'(d), 0, "command reads zero");
    guard = 0;
    while (d[0] !== 1'b0 || guard == 0) begin
      @(negedge clk);
      rd(3'd5, d);
      guard++;
      if (guard > 500) break;
    end
  endtask

  task automatic checkPattern(string req, logic [2:0] mask);
    int errs [NCH];
    for (int c = 0; c < NCH; c++) errs[c] = 0;
    for (int t = 0; t < 64; t++) begin
      for (int c = 0; c < NCH; c++) begin
        if (mask[c] && (sysClk[c] !== expLevel(curR[c], t))) errs[c]++;
      end
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) check(req, errs[c], 0, $sformatf("pattern mismatches ch%0d ratio %0d", c, curR[c]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < NCH; c++) curR[c] = c;

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(3'(c), d);
      check("R1", int'(d), 32'h8000 | c, $sformatf("divider %0d reset", c));
    end
    rd(3'd3, d); check("R1", int'(d), 0, "align reset");
    rd(3'd5, d); check("R1", int'(d), 0, "busy reset");
    rd(3'd6, d); check("R1", int'(d), 7, "enable status reset");

    // R10 reserved align bits
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); check("R10", int'(d), 7, "align reserved bits");

    // R2 default ratios
    for (int c = 0; c < NCH; c++) begin
      countHigh(c, 60, n);
      check("R2", n, expCount(c, 60), $sformatf("default high count ch%0d", c));
    end

    // R3 staged write does not change output
    wr(3'd0, 16'h8003);
    rd(3'd0, d); check("R3", int'(d), 32'h8003, "staged readback");
    countHigh(0, 60, n);
    check("R3", n, 60, "output keeps old ratio before GO");

    // R6 + R8: commit, ch1/ch2 unchanged but re-phased
    runGo("R6");
    curR[0] = 3;
    checkPattern("R6", 3'b001);
    runGo("R8");
    checkPattern("R8", 3'b110);

    // R5 second command while busy is dropped
    wr(3'd0, 16'h800B); wr(3'd1, 16'h800B); wr(3'd2, 16'h800B);
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0001);
    rd(3'd5, d);
    check("R5", int'(d[0]), 1, "busy while second command issued");
    while (d[0] == 1'b1) begin
      @(negedge clk);
      rd(3'd5, d);
    end
    for (int c = 0; c < NCH; c++) curR[c] = 11;
    n = 0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      rd(3'd5, d);
      n += int'(d[0]);
    end
    check("R5", n, 0, "no second GO after completion");

    // R7 unselected output keeps old ratio
    wr(3'd3, 16'h0003);
    wr(3'd0, 16'h8001); wr(3'd1, 16'h8003); wr(3'd2, 16'h8002);
    runGo("R7");
    curR[0] = 1; curR[1] = 3;
    checkPattern("R7", 3'b011);
    countHigh(2, 60, n);
    check("R7", n, expCount(11, 60), "unselected ch2 high count");
    rd(3'd2, d); check("R7", int'(d), 32'h8002, "unselected staged value kept");
    wr(3'd3, 16'h0007);
    runGo("R6");
    curR[2] = 2;
    checkPattern("R6", 3'b111);

    // R9 enable bit
    wr(3'd1, 16'h0003);
    rd(3'd6, d); check("R9", int'(d), 5, "enable status with ch1 off");
    countHigh(1, 20, n);
    check("R9", n, 0, "disabled output low");
    wr(3'd1, 16'h8003);
    rd(3'd6, d); check("R9", int'(d), 7, "enable status restored");
    countHigh(1, 60, n);
    check("R2", n, expCount(3, 60), "re-enabled ch1 high count");

    // random ratio sets, all selected
    for (int it = 0; it < 12; it++) begin
      for (int c = 0; c < NCH; c++) begin
        curR[c] = int'($urandom_range(0, 31));
        if (it == 0) curR[c] = 0;
        wr(3'(c), 16'h8000 | 16'(curR[c]));
      end
      runGo("R6");
      checkPattern("R6", 3'b111);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule